// File: doc/BRIEF.md
# Prioritized Interrupt Request Sequencer

This block stands between a set of interrupt sources and a processor core. Each source line may change at any time relative to the clock. The block resynchronizes each line and turns a rising edge into a pending flag. One cycle later the pending flag becomes a posted flag. A fixed-priority arbiter looks at the posted flags, and the lowest-numbered eligible interrupt is presented to the core as a request, together with its number and its branch address.

The core accepts the request by raising an acknowledge line. The block then drops the request and records the interrupt as the active one. It clears the pending flag of the served line first and its posted flag one cycle later. The active number that was in force before the interrupt is pushed onto a small nesting stack.

A lower-numbered interrupt may preempt the running one, up to a parameterized nesting depth. When the core signals completion, the previous active number is popped and restored. With nothing active, the active number reads an all-ones idle code and the address output is zero.

Top module: `irq_seq_top`

## Requirements
- R1: After an interrupt line rises, its bit in `pend_o` reads 1 after the third rising clock edge and reads 0 after the second.
- R2: A pending flag is set only by a rising edge of the synchronized line. A line that stays high after being served does not set the flag again.
- R3: A posted flag is set on the clock edge after its pending flag is first seen set, and never without a pending flag in the cycle before.
- R4: `req_o` rises on the edge after the post. `req_num_o` is the lowest posted number that is below the active number, and `vec_o` equals VEC_BASE + number × VEC_STRIDE.
- R5: While `req_o` is high and `ack_i` is low, `req_o`, `req_num_o` and `vec_o` stay unchanged. On the edge where `ack_i` is sampled high with `req_o` high, `req_o` falls.
- R6: On the edge after acceptance, the served bit of `pend_o` clears. The served bit of `post_o` clears one edge later.
- R7: On acceptance, `active_num_o` takes the accepted number, and `vec_o` then shows that number's address.
- R8: A posted interrupt whose number is equal to or higher than the active number raises no request until the active number changes.
- R9: A cycle with `done_i` high restores the active number that was in force before the current one was accepted. When nothing is active, `done_i` has no effect.
- R10: While nothing is active and no request is raised, `active_num_o` reads all ones (2^IDX_W − 1) and `vec_o` reads zero.
- R11: No new request is raised while `ack_i` is high, while a pending or posted clear is still in progress, or while NEST_DEPTH interrupts are active.
- R12: After reset, `req_o`, `pend_o`, `post_o` and `vec_o` are zero and `active_num_o` is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_IRQ | Interrupt lines, asynchronous to clk |
| ack_i | input | 1 | Core acknowledge of the request |
| done_i | input | 1 | Core end-of-service pulse |
| req_o | output | 1 | Interrupt request to the core |
| req_num_o | output | IDX_W | Number of the requested interrupt |
| vec_o | output | VEC_W | Branch address of the requested or active interrupt |
| active_num_o | output | IDX_W | Number of the interrupt in service, all ones when idle |
| pend_o | output | NUM_IRQ | Pending flags |
| post_o | output | NUM_IRQ | Posted flags |

## Verification
The bench builds the block with NUM_IRQ=8 and NEST_DEPTH=2, which gives IDX_W=4 and an idle code of 15. With a depth of two, the stack fills after one level of preemption. That makes it possible to check that a third, even higher-priority line waits until a completion frees a slot. VEC_BASE=0x100 and VEC_STRIDE=4 make every vector distinct and nonzero, so a wrong number, a wrong scale or a missing zero in idle shows up on `vec_o`. Random burst masks drive several lines at once and check the service order that results.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [1:0] {
    CLR_IDLE = 2'd0,
    CLR_PEND = 2'd1,
    CLR_POST = 2'd2
  } clr_phase_e;

  function automatic logic [31:0] vec_addr(input int unsigned base,
                                           input int unsigned stride,
                                           input int unsigned num);
    return 32'(base + num * stride);
  endfunction

endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] line_i,
  output logic [NUM_IRQ-1:0] rise_o
);
  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
    logic meta_q, sync_q, prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= line_i[g];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end
    assign rise_o[g] = sync_q & ~prev_q;
  end
endmodule

// File: rtl/irq_pend_post.sv
module irq_pend_post #(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] rise_i,
  input  logic [NUM_IRQ-1:0] clr_pend_i,
  input  logic [NUM_IRQ-1:0] clr_post_i,
  output logic [NUM_IRQ-1:0] pend_o,
  output logic [NUM_IRQ-1:0] post_o
);
  logic [NUM_IRQ-1:0] pend_q, pend_n, post_q, post_n;

  always_comb begin
    pend_n = (pend_q & ~clr_pend_i) | rise_i;
    post_n = (post_q | pend_q) & ~clr_post_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      post_q <= '0;
    end else begin
      pend_q <= pend_n;
      post_q <= post_n;
    end
  end

  assign pend_o = pend_q;
  assign post_o = post_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NUM_IRQ = 8,
  parameter int IDX_W   = 4
) (
  input  logic [NUM_IRQ-1:0] post_i,
  input  logic [IDX_W-1:0]   limit_i,
  output logic               win_valid_o,
  output logic [IDX_W-1:0]   win_num_o
);
  always_comb begin
    win_valid_o = 1'b0;
    win_num_o   = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (post_i[i] && (IDX_W'(i) < limit_i)) begin
        win_valid_o = 1'b1;
        win_num_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_nest_stack.sv
module irq_nest_stack #(
  parameter int DEPTH = 4,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [IDX_W-1:0] push_val_i,
  input  logic             pop_i,
  output logic [IDX_W-1:0] top_o,
  output logic             full_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [IDX_W-1:0] slot_q [DEPTH];

  always_comb begin
    cnt_n = cnt_q;
    if (push_i && !pop_i && cnt_q != CNT_W'(DEPTH)) cnt_n = cnt_q + 1'b1;
    else if (pop_i && !push_i && cnt_q != '0) cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    logic wr_en;
    assign wr_en = push_i && !pop_i && (cnt_q == CNT_W'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     slot_q[e] <= '0;
      else if (wr_en) slot_q[e] <= push_val_i;
    end
  end

  always_comb begin
    top_o = '1;
    for (int e = 0; e < DEPTH; e++) begin
      if (cnt_q == CNT_W'(e + 1)) top_o = slot_q[e];
    end
  end

  assign full_o = (cnt_q == CNT_W'(DEPTH));
endmodule

// File: rtl/irq_seq_top.sv
module irq_seq_top #(
  parameter int          NUM_IRQ    = 8,
  parameter int          NEST_DEPTH = 4,
  parameter int          VEC_W      = 16,
  parameter int unsigned VEC_BASE   = 16,
  parameter int unsigned VEC_STRIDE = 4,
  parameter int          IDX_W      = $clog2(NUM_IRQ) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               ack_i,
  input  logic               done_i,
  output logic               req_o,
  output logic [IDX_W-1:0]   req_num_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic [IDX_W-1:0]   active_num_o,
  output logic [NUM_IRQ-1:0] pend_o,
  output logic [NUM_IRQ-1:0] post_o
);
  import irq_seq_pkg::*;

  localparam logic [IDX_W-1:0] IDLE_NUM = '1;

  // reset: asserted at once, released through two flops
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  logic [NUM_IRQ-1:0] rise, clr_pend, clr_post;
  logic               win_valid, stk_full;
  logic [IDX_W-1:0]   win_num, stk_top;

  logic               req_q, req_n;
  logic [IDX_W-1:0]   num_q, num_n, active_q, active_n, clr_num_q, clr_num_n;
  logic [VEC_W-1:0]   vec_q, vec_n;
  clr_phase_e         phase_q, phase_n;
  logic               accept, retire, may_req;

  irq_edge_sync #(.NUM_IRQ(NUM_IRQ)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .line_i(irq_in), .rise_o(rise)
  );

  irq_pend_post #(.NUM_IRQ(NUM_IRQ)) u_flags (
    .clk(clk), .rst_n(rst_int_n), .rise_i(rise),
    .clr_pend_i(clr_pend), .clr_post_i(clr_post),
    .pend_o(pend_o), .post_o(post_o)
  );

  irq_arbiter #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_arb (
    .post_i(post_o), .limit_i(active_q),
    .win_valid_o(win_valid), .win_num_o(win_num)
  );

  irq_nest_stack #(.DEPTH(NEST_DEPTH), .IDX_W(IDX_W)) u_stack (
    .clk(clk), .rst_n(rst_int_n),
    .push_i(accept), .push_val_i(active_q), .pop_i(retire),
    .top_o(stk_top), .full_o(stk_full)
  );

  // clear masks for the served line, pending first then posted
  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_clr
    assign clr_pend[g] = (phase_q == CLR_PEND) && (clr_num_q == IDX_W'(g));
    assign clr_post[g] = (phase_q == CLR_POST) && (clr_num_q == IDX_W'(g));
  end

  assign accept  = req_q & ack_i;
  assign retire  = done_i & ~accept & (active_q != IDLE_NUM);
  assign may_req = win_valid & ~req_q & ~ack_i & ~done_i & ~stk_full
                 & (phase_q == CLR_IDLE);

  always_comb begin
    req_n     = req_q;
    num_n     = num_q;
    active_n  = active_q;
    phase_n   = phase_q;
    clr_num_n = clr_num_q;

    if (accept) begin
      req_n     = 1'b0;
      active_n  = num_q;
      phase_n   = CLR_PEND;
      clr_num_n = num_q;
    end else begin
      if (may_req) begin
        req_n = 1'b1;
        num_n = win_num;
      end
      if (retire) active_n = stk_top;
      case (phase_q)
        CLR_PEND: phase_n = CLR_POST;
        CLR_POST: phase_n = CLR_IDLE;
        default:  phase_n = CLR_IDLE;
      endcase
    end

    if (req_n)                    vec_n = VEC_W'(vec_addr(VEC_BASE, VEC_STRIDE, 32'(num_n)));
    else if (active_n != IDLE_NUM) vec_n = VEC_W'(vec_addr(VEC_BASE, VEC_STRIDE, 32'(active_n)));
    else                          vec_n = '0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      req_q     <= 1'b0;
      num_q     <= '0;
      active_q  <= IDLE_NUM;
      phase_q   <= CLR_IDLE;
      clr_num_q <= '0;
      vec_q     <= '0;
    end else begin
      req_q     <= req_n;
      num_q     <= num_n;
      active_q  <= active_n;
      phase_q   <= phase_n;
      clr_num_q <= clr_num_n;
      vec_q     <= vec_n;
    end
  end

  assign req_o        = req_q;
  assign req_num_o    = num_q;
  assign active_num_o = active_q;
  assign vec_o        = vec_q;
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
  parameter int NUM_IRQ = 8,
  parameter int VEC_W   = 16,
  parameter int IDX_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ack_i,
  input logic               req_o,
  input logic [IDX_W-1:0]   req_num_o,
  input logic [VEC_W-1:0]   vec_o,
  input logic [IDX_W-1:0]   active_num_o,
  input logic [NUM_IRQ-1:0] pend_o,
  input logic [NUM_IRQ-1:0] post_o
);
  localparam logic [IDX_W-1:0] IDLE_NUM = '1;

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !ack_i) |=> (req_o && $stable(req_num_o) && $stable(vec_o)));

  assert_req_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && ack_i) |=> !req_o);

  assert_active_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && ack_i) |=> (active_num_o == $past(req_num_o)));

  assert_post_after_pend_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (post_o != $past(post_o)) |-> ((post_o & ~$past(post_o) & ~$past(pend_o)) == '0));

  assert_req_posted_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_o) |-> ((req_num_o < IDX_W'(NUM_IRQ))
                      && |(post_o & (NUM_IRQ'(1) << req_num_o))));

  assert_no_req_under_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_o) |-> !$past(ack_i));

  assert_preempt_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_o) |-> (req_num_o < active_num_o));

  assert_idle_vec_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_o && active_num_o == IDLE_NUM) |-> (vec_o == '0));
endmodule

bind irq_seq_top irq_seq_chk #(.NUM_IRQ(NUM_IRQ), .VEC_W(VEC_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack_i(ack_i), .req_o(req_o), .req_num_o(req_num_o),
  .vec_o(vec_o), .active_num_o(active_num_o), .pend_o(pend_o), .post_o(post_o)
);

// File: tb/irq_seq_top_tb_top.sv
module irq_seq_top_tb_top;
  localparam int          N      = 8;
  localparam int          DEPTH  = 2;
  localparam int          VW     = 16;
  localparam int unsigned VBASE  = 32'h100;
  localparam int unsigned VSTEP  = 4;
  localparam int          IW     = $clog2(N) + 1;
  localparam int          IDLE   = (1 << IW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_in = '0;
  logic          ack_i = 1'b0;
  logic          done_i = 1'b0;
  logic          req_o;
  logic [IW-1:0] req_num_o, active_num_o;
  logic [VW-1:0] vec_o;
  logic [N-1:0]  pend_o, post_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  irq_seq_top #(.NUM_IRQ(N), .NEST_DEPTH(DEPTH), .VEC_W(VW),
                .VEC_BASE(VBASE), .VEC_STRIDE(VSTEP)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .ack_i(ack_i), .done_i(done_i),
    .req_o(req_o), .req_num_o(req_num_o), .vec_o(vec_o),
    .active_num_o(active_num_o), .pend_o(pend_o), .post_o(post_o)
  );

  function automatic int exp_vec(input int n);
    return int'(VBASE + n * VSTEP) & ((1 << VW) - 1);
  endfunction

  function automatic int lowest(input int mask);
    for (int i = 0; i < N; i++) if (mask[i]) return i;
    return -1;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic accept();
    ack_i = 1'b1;
    step(7);
    ack_i = 1'b0;
    step(1);
  endtask

  task automatic finish_isr();
    done_i = 1'b1;
    step(1);
    done_i = 1'b0;
  endtask

  task automatic wait_req(input int limit);
    for (int k = 0; k < limit && !req_o; k++) step(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    step(2);
    rst_n = 1'b1;
    step(4);
    // R12 reset state
    chk("R12 req", int'(req_o), 0);
    chk("R12 pend", int'(pend_o), 0);
    chk("R12 post", int'(post_o), 0);
    chk("R12 active", int'(active_num_o), IDLE);
    chk("R10 idle vec", int'(vec_o), 0);

    // R1 R3 R4 single line 3
    irq_in[3] = 1'b1;
    step(2);
    chk("R1 pend early", int'(pend_o), 0);
    step(1);
    chk("R1 pend set", int'(pend_o), 8);
    chk("R3 post not yet", int'(post_o), 0);
    step(1);
    chk("R3 post set", int'(post_o), 8);
    chk("R4 req not yet", int'(req_o), 0);
    step(1);
    chk("R4 req", int'(req_o), 1);
    chk("R4 num", int'(req_num_o), 3);
    chk("R4 vec", int'(vec_o), exp_vec(3));
    step(3);
    chk("R5 req held", int'(req_o), 1);
    chk("R5 num held", int'(req_num_o), 3);
    ack_i = 1'b1;
    step(1);
    chk("R5 req drop", int'(req_o), 0);
    chk("R7 active", int'(active_num_o), 3);
    chk("R7 vec", int'(vec_o), exp_vec(3));
    chk("R6 pend still", int'(pend_o), 8);
    step(1);
    chk("R6 pend cleared", int'(pend_o), 0);
    chk("R6 post still", int'(post_o), 8);
    step(1);
    chk("R6 post cleared", int'(post_o), 0);
    step(5);
    ack_i = 1'b0;
    step(6);
    chk("R2 held line no pend", int'(pend_o), 0);
    chk("R2 no new req", int'(req_o), 0);
    irq_in[3] = 1'b0;
    finish_isr();
    chk("R9 restore idle", int'(active_num_o), IDLE);
    chk("R10 vec zero", int'(vec_o), 0);
    finish_isr();
    chk("R9 done ignored", int'(active_num_o), IDLE);
    chk("R9 done ignored req", int'(req_o), 0);

    // R8 R11 nesting with depth 2
    irq_in[5] = 1'b1;
    step(5);
    chk("R4 num 5", int'(req_num_o), 5);
    accept();
    chk("R7 active 5", int'(active_num_o), 5);
    irq_in[6] = 1'b1;
    step(8);
    chk("R8 lower prio waits", int'(req_o), 0);
    chk("R8 lower prio posted", int'(post_o[6]), 1);
    irq_in[2] = 1'b1;
    step(5);
    chk("R8 preempt req", int'(req_o), 1);
    chk("R8 preempt num", int'(req_num_o), 2);
    accept();
    chk("R7 active 2", int'(active_num_o), 2);
    irq_in[0] = 1'b1;
    step(8);
    chk("R11 depth full", int'(req_o), 0);
    finish_isr();
    chk("R9 restore 5", int'(active_num_o), 5);
    chk("R9 vec 5", int'(vec_o), exp_vec(5));
    step(1);
    chk("R11 freed slot req", int'(req_o), 1);
    chk("R11 freed slot num", int'(req_num_o), 0);
    accept();
    finish_isr();
    chk("R9 back to 5", int'(active_num_o), 5);
    finish_isr();
    chk("R9 back to idle", int'(active_num_o), IDLE);
    wait_req(4);
    chk("R8 waiting line served", int'(req_num_o), 6);
    accept();
    finish_isr();
    irq_in = '0;
    step(4);

    // R11 ack high blocks a new request
    ack_i = 1'b1;
    irq_in[4] = 1'b1;
    step(8);
    chk("R11 ack blocks", int'(req_o), 0);
    ack_i = 1'b0;
    step(1);
    chk("R11 req after ack low", int'(req_o), 1);
    chk("R11 num 4", int'(req_num_o), 4);
    accept();
    finish_isr();
    irq_in = '0;
    step(4);

    // R4 random bursts: service order is ascending
    for (int round = 0; round < 20; round++) begin
      int mask;
      mask = int'($urandom & 32'hFF);
      if (mask == 0) mask = 1 << (round % N);
      irq_in = N'(mask);
      step(6);
      irq_in = '0;
      while (mask != 0) begin
        int want;
        want = lowest(mask);
        wait_req(12);
        chk("R4 burst req", int'(req_o), 1);
        chk("R4 burst num", int'(req_num_o), want);
        chk("R4 burst vec", int'(vec_o), exp_vec(want));
        accept();
        finish_isr();
        mask &= ~(1 << want);
      end
      step(2);
      chk("R10 burst idle", int'(active_num_o), IDLE);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule